// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers level-sensitive request lines into several identical banks of 32 lines each and raises one summary interrupt per bank toward a separate CPU interrupt input. Every request line that is high on a clock edge sets a sticky pending bit. Software clears a pending bit by writing a one to it. A per-bank enable register decides which pending bits reach the bank's summary line.

Software reaches every bank through one single-cycle register port. The banks are laid out back to back at a fixed byte stride. In its interrupt handler, software reads the bank's enabled-pending view. It takes the most significant set bit as the active source, and a zero value means nothing is pending in that bank. To mask and acknowledge a source, software first clears its enable bit and then writes a one to its pending bit. A raw view shows the live request lines, and a spare mask register gives plain read/write storage in each bank.

Top module: `icu_banked`

## Requirements
- R1: After reset, every pending, enable and mask register reads zero and every summary output is low.
- R2: Bank b occupies byte addresses b*0x28 to b*0x28+0x27. Inside a bank the offsets are: 0x00 pending status (read, write-one-to-clear), 0x08 enable (read/write), 0x10 enabled-pending view (read only), 0x18 raw request view (read only) and 0x20 mask storage (read/write). An access to one bank never changes another bank.
- R3: A pending bit is set on every clock edge at which its request line is high, and it stays set after the request drops.
- R4: Writing 1 to a bit at offset 0x00 clears that pending bit. Writing 0 to a bit leaves it unchanged.
- R5: When a clear write and a high request hit the same bit on the same edge, the bit ends up set.
- R6: The enable register reads back the last value written to it. The enabled-pending view returns the bitwise AND of pending status and enable.
- R7: Summary output b is high exactly when bank b's enabled-pending view is nonzero. It follows a register change on the same edge, with no extra delay.
- R8: The raw view returns the bank's current request lines combinationally.
- R9: The mask register reads back the last value written to it and has no effect on pending bits, the views or the summary outputs.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses, and writes to the two read-only views, change no state.
- R11: Clearing an enable bit drops the summary line after that write's edge. A following write-one-to-clear leaves the bank with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_BANKS*LINES | Level request lines; bank b uses bits b*LINES and up |
| addr | input | ADDR_W | Byte address of the register port |
| wrEn | input | 1 | Write strobe, taken at the clock edge |
| wrData | input | LINES | Write data |
| rdData | output | LINES | Combinational read data for addr |
| irqOut | output | NUM_BANKS | Per-bank summary interrupt |

## Verification
The bound checker checks four things on every cycle. A high request is always latched, even against a simultaneous clear. Pending bits never drop without a write. Enable registers hold unless a mapped write occurs. A bank with a zero enable never raises its summary line. The bench scenarios cover the rest: the exact address map, write-one-to-clear against write-zero, the AND view, the raw view, the inert mask storage and the mask-and-acknowledge sequence. The bench sweeps every line of every bank and every address of the port.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_ENABLE = 'h08;
  localparam int OFF_PEND   = 'h10;
  localparam int OFF_RAW    = 'h18;
  localparam int OFF_MASK   = 'h20;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_ENABLE,
    SEL_PEND,
    SEL_RAW,
    SEL_MASK
  } regSel_e;

  typedef struct packed {
    logic    hit;
    logic    wr;
    regSel_e sel;
  } icuStrobe_t;
endpackage

// File: rtl/icu_decode.sv
module icu_decode import icu_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int STRIDE    = 'h28,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output icuStrobe_t        strb,
  output logic [BANK_W-1:0] bankIdx
);
  logic [ADDR_W-1:0] quot;
  logic [ADDR_W-1:0] offs;
  logic              inBank;
  logic              offValid;
  regSel_e           sel;

  assign quot    = addr / ADDR_W'(STRIDE);
  assign offs    = addr % ADDR_W'(STRIDE);
  assign inBank  = quot < ADDR_W'(NUM_BANKS);
  assign bankIdx = quot[BANK_W-1:0];

  always_comb begin
    offValid = 1'b1;
    sel      = SEL_STATUS;
    if (offs == ADDR_W'(OFF_STATUS))      sel = SEL_STATUS;
    else if (offs == ADDR_W'(OFF_ENABLE)) sel = SEL_ENABLE;
    else if (offs == ADDR_W'(OFF_PEND))   sel = SEL_PEND;
    else if (offs == ADDR_W'(OFF_RAW))    sel = SEL_RAW;
    else if (offs == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
    else                                  offValid = 1'b0;
  end

  assign strb.hit = inBank && offValid;
  assign strb.wr  = wrEn && inBank && offValid;
  assign strb.sel = sel;
endmodule

// File: rtl/icu_bank_array.sv
module icu_bank_array import icu_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int BANK_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_BANKS*LINES-1:0] reqIn,
  input  icuStrobe_t                 strb,
  input  logic [BANK_W-1:0]          bankIdx,
  input  logic [LINES-1:0]           wrData,
  output logic [LINES-1:0]           rdData,
  output logic [NUM_BANKS-1:0]       irqOut,
  output logic [NUM_BANKS*LINES-1:0] statusFlat,
  output logic [NUM_BANKS*LINES-1:0] enableFlat
);
  logic [NUM_BANKS*LINES-1:0] maskFlat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic             bankWr;
    logic [LINES-1:0] statusQ, enableQ, maskQ, clrBits, reqBits;

    assign bankWr  = strb.wr && (bankIdx == BANK_W'(b));
    assign reqBits = reqIn[b*LINES +: LINES];
    assign clrBits = (bankWr && strb.sel == SEL_STATUS) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ <= '0;
        enableQ <= '0;
        maskQ   <= '0;
      end else begin
        statusQ <= (statusQ & ~clrBits) | reqBits;
        if (bankWr && strb.sel == SEL_ENABLE) enableQ <= wrData;
        if (bankWr && strb.sel == SEL_MASK)   maskQ   <= wrData;
      end
    end

    assign statusFlat[b*LINES +: LINES] = statusQ;
    assign enableFlat[b*LINES +: LINES] = enableQ;
    assign maskFlat[b*LINES +: LINES]   = maskQ;
    assign irqOut[b] = |(statusQ & enableQ);
  end

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      case (strb.sel)
        SEL_STATUS: rdData = statusFlat[int'(bankIdx)*LINES +: LINES];
        SEL_ENABLE: rdData = enableFlat[int'(bankIdx)*LINES +: LINES];
        SEL_PEND:   rdData = statusFlat[int'(bankIdx)*LINES +: LINES]
                           & enableFlat[int'(bankIdx)*LINES +: LINES];
        SEL_RAW:    rdData = reqIn[int'(bankIdx)*LINES +: LINES];
        SEL_MASK:   rdData = maskFlat[int'(bankIdx)*LINES +: LINES];
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/icu_banked.sv
module icu_banked import icu_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int STRIDE    = 'h28,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_BANKS*LINES-1:0] reqIn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic [LINES-1:0]           wrData,
  output logic [LINES-1:0]           rdData,
  output logic [NUM_BANKS-1:0]       irqOut
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  icuStrobe_t                 strb;
  logic [BANK_W-1:0]          bankIdx;
  logic [NUM_BANKS*LINES-1:0] statusFlat;
  logic [NUM_BANKS*LINES-1:0] enableFlat;

  icu_decode #(
    .NUM_BANKS(NUM_BANKS), .STRIDE(STRIDE), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_decode (
    .addr(addr), .wrEn(wrEn), .strb(strb), .bankIdx(bankIdx)
  );

  icu_bank_array #(
    .NUM_BANKS(NUM_BANKS), .LINES(LINES), .BANK_W(BANK_W)
  ) u_banks (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strb(strb), .bankIdx(bankIdx),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .statusFlat(statusFlat), .enableFlat(enableFlat)
  );
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_BANKS*LINES-1:0] reqIn,
  input logic                       wrEn,
  input logic                       hit,
  input logic [NUM_BANKS*LINES-1:0] statusFlat,
  input logic [NUM_BANKS*LINES-1:0] enableFlat,
  input logic [NUM_BANKS-1:0]       irqOut
);
  AST_REQ_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusFlat & $past(reqIn)) == $past(reqIn))); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((statusFlat & $past(statusFlat)) == $past(statusFlat))); // R3

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || !hit) |=> (enableFlat == $past(enableFlat))); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gIrq
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
      (enableFlat[b*LINES +: LINES] == '0) |-> !irqOut[b]); // R7
  end
endmodule

bind icu_banked icu_checker #(.NUM_BANKS(NUM_BANKS), .LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .hit(strb.hit),
  .statusFlat(statusFlat), .enableFlat(enableFlat), .irqOut(irqOut)
);

// File: tb/test_icu_banked.sv
module test_icu_banked;
  localparam int NB = 5, LN = 32, STR = 'h28, AW = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NB*LN-1:0]  reqIn = '0;
  logic [AW-1:0]     addr = '0;
  logic              wrEn = 1'b0;
  logic [LN-1:0]     wrData = '0;
  logic [LN-1:0]     rdData;
  logic [NB-1:0]     irqOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [LN-1:0] expStat [NB];
  logic [LN-1:0] expEn   [NB];
  logic [LN-1:0] expMask [NB];

  always #10 clk = ~clk;

  icu_banked i_icu_banked (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(string req, logic [LN-1:0] act, logic [LN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(int a, logic [LN-1:0] d);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(int a, output logic [LN-1:0] d);
    @(negedge clk);
    addr = AW'(a);
    #2 d = rdData;
  endtask

  task automatic pulse(int b, logic [LN-1:0] pat);
    @(negedge clk);
    reqIn[b*LN +: LN] = pat;
    @(negedge clk);
    reqIn = '0;
  endtask

  function automatic logic [NB-1:0] expIrq();
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = |(expStat[b] & expEn[b]);
    return v;
  endfunction

  function automatic bit isMapped(int a);
    int bk = a / STR;
    int of = a % STR;
    return bk < NB && (of == 0 || of == 8 || of == 16 || of == 24 || of == 32);
  endfunction

  task automatic checkAllRegs(string req);
    logic [LN-1:0] d;
    for (int b = 0; b < NB; b++) begin
      doRead(b*STR + 'h00, d); check(req, d, expStat[b]);
      doRead(b*STR + 'h08, d); check(req, d, expEn[b]);
      doRead(b*STR + 'h20, d); check(req, d, expMask[b]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LN-1:0] d, p, e;
    for (int b = 0; b < NB; b++) begin
      expStat[b] = '0; expEn[b] = '0; expMask[b] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkAllRegs("R1");
    #1 check("R1 irq", LN'(irqOut), '0);

    // R3 / R4 / R2: every line of every bank
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < LN; i++) begin
        p = LN'(1) << i;
        pulse(b, p);
        doRead(b*STR, d);                 check("R3 latch", d, p);
        doRead(((b+1)%NB)*STR, d);        check("R2 other bank", d, '0);
        doWrite(b*STR, ~p);
        doRead(b*STR, d);                 check("R4 write zero", d, p);
        doWrite(b*STR, p);
        doRead(b*STR, d);                 check("R4 clear", d, '0);
      end
    end

    // R6 / R7: enable readback, AND view, summary lines
    for (int b = 0; b < NB; b++) begin
      expEn[b] = 32'hF0F0_3C3C ^ (LN'(b) * 32'h0101_1111);
      doWrite(b*STR + 'h08, expEn[b]);
      doRead(b*STR + 'h08, d); check("R6 enable readback", d, expEn[b]);
    end
    for (int b = 0; b < NB; b++) begin
      p = (b == 2) ? ~expEn[b] : (32'h1234_5678 << b);
      pulse(b, p);
      expStat[b] = p;
    end
    for (int b = 0; b < NB; b++) begin
      doRead(b*STR + 'h10, d); check("R6 pending view", d, expStat[b] & expEn[b]);
    end
    #1 check("R7 irq", LN'(irqOut), LN'(expIrq()));

    // R8: raw view follows live requests
    @(negedge clk);
    for (int b = 0; b < NB; b++) reqIn[b*LN +: LN] = 32'hA000_0001 | (LN'(b) << 8);
    for (int b = 0; b < NB; b++) begin
      doRead(b*STR + 'h18, d); check("R8 raw", d, 32'hA000_0001 | (LN'(b) << 8));
    end
    for (int b = 0; b < NB; b++) expStat[b] |= 32'hA000_0001 | (LN'(b) << 8);
    @(negedge clk) reqIn = '0;
    doRead(STR + 'h18, d); check("R8 raw idle", d, '0);

    // R9: mask storage is inert
    for (int b = 0; b < NB; b++) begin
      expMask[b] = 32'hFFFF_FFFF >> b;
      doWrite(b*STR + 'h20, expMask[b]);
      doRead(b*STR + 'h20, d); check("R9 mask readback", d, expMask[b]);
      doRead(b*STR + 'h10, d); check("R9 pending unaffected", d, expStat[b] & expEn[b]);
    end
    #1 check("R9 irq unaffected", LN'(irqOut), LN'(expIrq()));

    // R10: unmapped reads zero, stray writes change nothing
    for (int a = 0; a < 256; a++) begin
      if (!isMapped(a)) begin
        doRead(a, d); check("R10 unmapped read", d, '0);
      end
    end
    for (int a = 0; a < 256; a++) begin
      if (!isMapped(a) || (a % STR) == 'h10 || (a % STR) == 'h18)
        doWrite(a, '1);
    end
    checkAllRegs("R10 no change");

    // R5: request beats a same-cycle clear
    for (int b = 0; b < NB; b++) begin
      doWrite(b*STR, '1); expStat[b] = '0;
    end
    @(negedge clk);
    reqIn[7] = 1'b1;
    addr = AW'(0); wrData = '1; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; reqIn = '0;
    doRead(0, d); check("R5 request wins", d, 32'h0000_0080);
    doWrite(0, 32'h0000_0080);
    doRead(0, d); check("R5 cleared after", d, '0);

    // R11: mask-and-acknowledge
    doWrite(3*STR + 'h08, 32'h0000_0020); expEn[3] = 32'h0000_0020;
    pulse(3, 32'h0000_0020);
    #1 check("R11 irq raised", LN'(irqOut[3]), 1);
    doWrite(3*STR + 'h08, '0);
    #1 check("R11 irq dropped", LN'(irqOut[3]), 0);
    doWrite(3*STR, 32'h0000_0020);
    doRead(3*STR, d);        check("R11 status clear", d, '0);
    doRead(3*STR + 'h10, d); check("R11 pending view", d, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule